// File: doc/BRIEF.md
# Configurable-Ratio Serial Lane Transmitter

This block turns parallel words into a single serial bit stream. One clock, the bit clock, runs at the serial rate. A static factor J sets how many bits make up each word. J may be 3, 4, 6, 7, 8 or 10. An internal counter raises a take strobe for one bit-clock cycle in every J. On the rising edge where the strobe is high, the low J bits of the parallel input are copied into a shift register. The register then sends one bit per bit-clock cycle, with the highest used bit first. Each new word is captured in the same edge that moves the last bit of the previous word out, so the words follow each other with no gap.

The same lane can be built as a clock lane instead of a data lane. A clock lane ignores the parallel input and loads a fixed pattern. That pattern forms a clock at the bit rate divided by D:

- D = 1 passes the bit clock itself through, gated until the first capture.
- An even D repeats D/2 ones followed by D/2 zeros.

The forwarded clock is either edge aligned (it rises at word boundaries) or center aligned (inverted, so it rises mid-pattern). D must be 1, or an even number that divides J. Any other factor or divisor stops elaboration with an error. From reset until the first capture, the output stays low.

Top module: `ser_lane_tx`

## Requirements
- R1: After reset is released, `word_take` is high in the first bit-clock cycle. `ser_out` is low from reset until the rising edge that performs the first capture.
- R2: `word_take` is high for exactly one bit-clock cycle in every J cycles.
- R3: In a data lane, the word on `par_in` at the rising edge where `word_take` is high appears on `ser_out` over the next J cycles. Bit J-1 comes first and bit 0 comes last, one bit per cycle. The first bit appears in the cycle after that edge.
- R4: In a data lane, consecutive words follow with no idle cycle. The cycle after bit 0 of one word carries bit J-1 of the next word.
- R5: Bits of `par_in` at positions J and above have no effect on `ser_out`.
- R6: In a clock lane with an even divisor D and edge alignment, `ser_out` repeats D/2 ones and then D/2 zeros. The first one appears in the cycle after the first capture, so each J-bit word begins on a rising clock edge.
- R7: In a clock lane with center alignment, the R6 pattern is inverted. The output is low in the first D/2 cycles after each word boundary.
- R8: In a clock lane with D = 1, after the first capture `ser_out` equals the bit clock (edge aligned) or its inverse (center aligned).
- R9: A clock lane ignores `par_in` completely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | W (10) | Parallel word; only the low J bits are used |
| word_take | output | 1 | High in the cycle whose closing edge captures `par_in` |
| ser_out | output | 1 | Serial data, or the forwarded clock in a clock lane |

## Verification
The assertions check these properties on every cycle:

- The take strobe never lasts more than one cycle.
- The shift register holds exactly the word sampled at the previous take edge.
- Each later cycle moves the next lower bit to the output.
- The output stays quiet until the first capture.
- A divided forwarded clock repeats with period D and starts at the right level.

Other properties need the bench's scenarios. The bench applies word streams with junk in the unused upper bits and rebuilds them from the serial stream, for every legal factor. It checks clock lanes of several divisors and both phases against the expected pattern while `par_in` keeps changing. For D = 1, it samples inside each half of the bit clock.

// File: rtl/ser_pkg.sv
package ser_pkg;

  localparam int SER_MAX_W = 10;

  typedef logic [SER_MAX_W-1:0] ser_word_t;

  // Serialization factors the lane supports.
  function automatic bit factor_ok(input int j);
    return (j == 3) || (j == 4) || (j == 6) || (j == 7) || (j == 8) || (j == 10);
  endfunction

  // A divisor is legal when it is 1, or even and a whole number of periods fits in a word.
  function automatic bit div_ok(input int j, input int d);
    if (d == 1) return 1'b1;
    return (d >= 2) && ((d % 2) == 0) && ((j % d) == 0);
  endfunction

  // Forwarded clock word: the bit sent i cycles after capture is high in the
  // first half of each D-cycle period; inv flips it for the center-aligned phase.
  function automatic ser_word_t fwd_pattern(input int j, input int d, input bit inv);
    ser_word_t p;
    p = '0;
    for (int i = 0; i < j; i++) begin
      int pos;
      pos = j - 1 - i;
      p[pos] = (((i % d) < (d / 2)) ? 1'b1 : 1'b0) ^ inv;
    end
    return p;
  endfunction

  // Mask of the used low bits for factor j.
  function automatic ser_word_t use_mask(input int j);
    ser_word_t m;
    m = '0;
    for (int i = 0; i < j; i++) m[i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/ser_load_gen.sv
module ser_load_gen #(
  parameter int J = 10
) (
  input  logic bit_clk,
  input  logic rst_n,
  output logic take
);
  localparam int CW = $clog2(J);
  localparam logic [CW-1:0] LAST = CW'(J - 1);

  logic [CW-1:0] cnt;

  assign take = (cnt == LAST);

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n)    cnt <= LAST;
    else if (take) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end

  AST_TAKE_SINGLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    take |=> !take) else $error("take strobe lasted more than one cycle"); // R2

endmodule

// File: rtl/ser_shift_reg.sv
module ser_shift_reg #(
  parameter int W = 10,
  parameter int J = 10
) (
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         ser_bit,
  output logic         valid
);
  logic [W-1:0] sreg;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      sreg  <= din;
      valid <= 1'b1;
    end else begin
      sreg  <= {sreg[W-2:0], 1'b0};
    end
  end

  assign ser_bit = sreg[J-1];

  AST_LOAD_CAPTURE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    load |=> (sreg == $past(din))) else $error("word not captured"); // R3

  AST_SHIFT_STEP: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!load && valid) |=> (sreg[J-1] == $past(sreg[J-2]))) else $error("shift skipped"); // R3

  AST_QUIET_BEFORE_LOAD: assert property (@(posedge bit_clk) disable iff (!rst_n)
    !valid |-> !ser_bit) else $error("output active before first load"); // R1

endmodule

// File: rtl/ser_out_stage.sv
module ser_out_stage #(
  parameter bit CLOCK_LANE = 1'b0,
  parameter int FWD_DIV    = 1,
  parameter bit FWD_INVERT = 1'b0
) (
  input  logic bit_clk,
  input  logic valid,
  input  logic ser_bit,
  output logic lane_out
);
  localparam bit PASS_CLK = CLOCK_LANE && (FWD_DIV == 1);

  generate
    if (PASS_CLK) begin : g_pass_clk
      logic unused_ser;
      assign unused_ser = ser_bit;
      assign lane_out   = valid & (bit_clk ^ FWD_INVERT);
    end else begin : g_shift_out
      logic unused_clk;
      assign unused_clk = bit_clk ^ valid;
      assign lane_out   = ser_bit;
    end
  endgenerate

endmodule

// File: rtl/ser_lane_tx.sv
module ser_lane_tx
  import ser_pkg::*;
#(
  parameter int W          = SER_MAX_W,
  parameter int FACTOR     = 10,
  parameter bit CLOCK_LANE = 1'b0,
  parameter int FWD_DIV    = 1,
  parameter bit FWD_INVERT = 1'b0
) (
  input  logic         bit_clk,
  input  logic         rst_n,
  input  logic [W-1:0] par_in,
  output logic         word_take,
  output logic         ser_out
);
  localparam ser_word_t FWD_WORD = fwd_pattern(FACTOR, FWD_DIV, FWD_INVERT);
  localparam ser_word_t MASK     = use_mask(FACTOR);
  localparam bit        LEGAL    = factor_ok(FACTOR) &&
                                   (!CLOCK_LANE || div_ok(FACTOR, FWD_DIV)) &&
                                   (W == SER_MAX_W);

  generate
    if (!LEGAL) begin : g_bad_setting
      $error("ser_lane_tx: illegal factor/divisor/width combination");
    end
  endgenerate

  // Named internal events for the checks.
  logic      take_evt;
  logic      word_valid;
  logic      shift_bit;
  ser_word_t load_word;

  ser_load_gen #(.J(FACTOR)) u_load_gen (
    .bit_clk (bit_clk),
    .rst_n   (rst_n),
    .take    (take_evt)
  );

  assign load_word = CLOCK_LANE ? FWD_WORD : (ser_word_t'(par_in) & MASK);

  ser_shift_reg #(.W(SER_MAX_W), .J(FACTOR)) u_shift (
    .bit_clk (bit_clk),
    .rst_n   (rst_n),
    .load    (take_evt),
    .din     (load_word),
    .ser_bit (shift_bit),
    .valid   (word_valid)
  );

  ser_out_stage #(
    .CLOCK_LANE (CLOCK_LANE),
    .FWD_DIV    (FWD_DIV),
    .FWD_INVERT (FWD_INVERT)
  ) u_out (
    .bit_clk  (bit_clk),
    .valid    (word_valid),
    .ser_bit  (shift_bit),
    .lane_out (ser_out)
  );

  assign word_take = take_evt;

  AST_VALID_AFTER_TAKE: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(word_valid) |-> $past(take_evt)) else $error("valid without capture"); // R1

  generate
    if (CLOCK_LANE && FWD_DIV > 1) begin : g_fwd_checks
      AST_FWD_PERIOD: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (word_valid && $past(word_valid, FWD_DIV)) |-> (ser_out == $past(ser_out, FWD_DIV)))
        else $error("forwarded clock period broken"); // R6
      AST_FWD_ALIGN: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(word_valid) |-> (ser_out == !FWD_INVERT))
        else $error("forwarded clock phase wrong"); // R7
    end
  endgenerate

endmodule

// File: tb/tb_ser_lane_tx.sv
module tb_ser_lane_tx;

  localparam time HALF = 10ns;       // 50 MHz bit clock
  localparam int  NW   = 12;         // words per data lane
  localparam int  ND   = 6;
  localparam int  NC   = 5;
  localparam int  DATA_J [ND] = '{3, 4, 6, 7, 8, 10};
  localparam int  CLK_J  [NC] = '{8, 6, 10, 7, 4};
  localparam int  CLK_D  [NC] = '{4, 6, 2, 1, 1};
  localparam bit  CLK_I  [NC] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   n_checks = 0;
  int   n_fail = 0;
  int   lanes_done = 0;
  bit   wd_hit = 1'b0;

  always #HALF clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Words carry junk above the used bits so that R5 is exercised.
  function automatic logic [9:0] gen_word(input int k, input int g);
    case (k)
      0: return 10'h3FF;
      1: return 10'h000;
      2: return 10'h2AA;
      3: return 10'h155;
      default: return 10'((k * 37 + g * 101 + 5) ^ (k << 4) ^ 10'h2C3);
    endcase
  endfunction

  // ---------------- data lanes (scoreboard per lane) ----------------
  for (genvar g = 0; g < ND; g++) begin : g_data
    localparam int J = DATA_J[g];
    localparam logic [9:0] MSK = 10'((1 << J) - 1);
    logic [9:0] par;
    logic       take, sout;
    logic [9:0] exp_q [$];

    ser_lane_tx #(.FACTOR(J)) dut (
      .bit_clk(clk), .rst_n(rst_n), .par_in(par), .word_take(take), .ser_out(sout));

    // driver
    initial begin
      par = gen_word(0, g);
      wait (rst_n === 1'b1);
      for (int k = 0; k < NW; k++) begin
        while (take !== 1'b1) @(negedge clk);
        exp_q.push_back(par & MSK);
        @(posedge clk);
        #1 par = gen_word(k + 1, g);
        @(negedge clk);
      end
    end

    // monitor
    initial begin
      wait (rst_n === 1'b1);
      check(sout === 1'b0, "R1 quiet before first capture", int'(sout), 0);
      check(take === 1'b1, "R1 take in first cycle", int'(take), 1);
      @(posedge clk);
      for (int w = 0; w < NW - 1; w++) begin
        logic [9:0] acc;
        logic [9:0] exp_w;
        acc = '0;
        for (int b = 0; b < J; b++) begin
          @(negedge clk);
          acc = {acc[8:0], sout};
          if (b == J - 1) check(take === 1'b1, "R2 take at last bit", int'(take), 1);
          else if (take !== 1'b0) check(1'b0, "R2 take off mid-word", int'(take), 0);
        end
        exp_w = (exp_q.size() > 0) ? exp_q.pop_front() : 10'h3FF;
        check(acc == exp_w, "R3 R4 R5 word rebuilt", int'(acc), int'(exp_w));
      end
      lanes_done++;
    end
  end

  // ---------------- clock lanes ----------------
  for (genvar g = 0; g < NC; g++) begin : g_clk
    localparam int J = CLK_J[g];
    localparam int D = CLK_D[g];
    localparam bit I = CLK_I[g];
    logic [9:0] par;
    logic       take, sout;

    ser_lane_tx #(.FACTOR(J), .CLOCK_LANE(1'b1), .FWD_DIV(D), .FWD_INVERT(I)) dut (
      .bit_clk(clk), .rst_n(rst_n), .par_in(par), .word_take(take), .ser_out(sout));

    // R9: par_in keeps changing and must not matter
    initial begin
      par = 10'h000;
      forever begin
        @(posedge clk);
        #2 par = par + 10'h137;
      end
    end

    initial begin
      wait (rst_n === 1'b1);
      #1 check(sout === 1'b0, "R1 clock lane quiet before capture", int'(sout), 0);
      @(posedge clk);
      if (D > 1) begin
        for (int i = 0; i < 4 * J; i++) begin
          logic e;
          @(negedge clk);
          e = (((i % D) < (D / 2)) ? 1'b1 : 1'b0) ^ I;
          check(sout === e, I ? "R7 R9 center-aligned pattern" : "R6 R9 edge-aligned pattern",
                int'(sout), int'(e));
        end
      end else begin
        for (int i = 0; i < 8; i++) begin
          #5 check(sout === !I, "R8 high phase of bit clock", int'(sout), int'(!I));
          @(negedge clk);
          #5 check(sout === I, "R8 low phase of bit clock", int'(sout), int'(I));
          @(posedge clk);
        end
      end
      lanes_done++;
    end
  end

  // reset and watchdog
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    #(HALF * 2 * 20000);
    wd_hit = 1'b1;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d lanes done expected %0d", lanes_done, ND + NC);
  end

  initial begin
    wait (lanes_done == ND + NC || wd_hit);
    #1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule